// File: doc/BRIEF.md
# Keyed Indexed Configuration Port

This block is the setup interface of a multi-function peripheral controller, reached over a byte-wide host I/O bus. There are two ports. The base port (`bus_port` = 0) takes key bytes and register indices. The data port (`bus_port` = 1) reads or writes the register that the last index names. After reset the block is locked. Two writes of 0x55 to the base port in a row open it, and a write of 0xAA to the base port locks it again.

While the block is open, global register 0x07 selects one of nine logical devices, numbered 0 to 8. Device 0 is the floppy, 1 and 2 are IDE, 3 is the parallel port, 4 and 5 are serial, 6 is the clock, 7 is the keyboard and 8 is auxiliary I/O. Each device has its own bank of settings: enable, 16-bit base address, interrupt number and, on some devices, a DMA channel or a second interrupt. These settings drive parallel output pins that the surrounding chip uses to place and wire the functions.

The block decodes no function addresses and contains none of the functions' logic.

Top module: `cfgport_top`

## Requirements
- R1: The block opens only on the second of two base-port writes of 0x55. After a single 0x55 it stays locked, and data-port reads still return 0xFF.
- R2: While one 0x55 is pending, any other write cancels the pending key. This includes a data-port write, or a base-port write of a value other than 0x55.
- R3: While open, a base-port write of 0xAA locks the block. Any other base-port write sets the register index.
- R4: While locked, data-port reads return 0xFF, and data-port writes change no register or output.
- R5: Index 0x20 reads 0x02 and index 0x21 reads the revision parameter (0x01 by default). Writes to either index have no effect.
- R6: Index 0x07 holds the logical device number and reads it back. A write of a value above 8 is ignored.
- R7: In the selected device's bank, these indices hold the settings. Index 0x30 bit 0 is the enable. Index 0x60 is the high address byte and 0x61 the low byte, giving `dev_base` = {0x60, 0x61}. Index 0x70 is the interrupt, which keeps its low 4 bits. Banks are independent of each other.
- R8: Index 0x72 exists only for device 7. It keeps 4 bits and drives `kbd_irq2`. For any other device it reads 0x00 and writes are ignored.
- R9: Index 0x74 exists only for devices 0 and 3. It keeps 3 bits and drives that device's `dev_dma` field. For other devices it reads 0x00, writes are ignored, and their `dev_dma` field stays 0.
- R10: Device 0 has full 8-bit read/write registers at 0x90 and 0x91. A read-modify-write of 0x90 preserves the bits it does not change. For other devices both indices read 0x00.
- R11: Index 0x22 reads bit n as the enable of device n for n = 0 to 5. Bits 7:6 read 0.
- R12: Indices that are not implemented read 0x00, and writes to them change no register or output.
- R13: A data write changes the outputs at the next clock edge. Reset leaves the block locked, with every device disabled and every address, interrupt and DMA output at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per byte |
| bus_rd | input | 1 | Read strobe; `bus_rdata` is valid in the same cycle |
| bus_port | input | 1 | 0 = base (key/index) port, 1 = data port |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Read byte, 0x00 when `bus_rd` is low |
| dev_active | output | NDEV | Per-device enable |
| dev_base | output | NDEV*16 | Per-device base address, device i at bits [16i+15:16i] |
| dev_irq | output | NDEV*IRQ_W | Per-device interrupt number |
| dev_dma | output | NDEV*DMA_W | Per-device DMA channel, 0 for devices without one |
| kbd_irq2 | output | IRQ_W | Second interrupt of the keyboard device |

## Verification
The unlock logic is tried with three patterns: one key byte, two key bytes with a data-port write between them, and two key bytes with a non-key base write between them. Only a clean pair may read the device ID instead of 0xFF. The bank logic is tried by programming different addresses and interrupts into two serial banks. This separates a shared register from a per-device one. The same optional index is then written for a device that has it and one that lacks it, which tells a correctly gated optional register from one present everywhere. A write that lands while the block is locked, a write of an out-of-range device number, and a write to an unused index are each followed by readback of the affected outputs, which shows whether the write leaked into state.

// File: rtl/cfgport_pkg.sv
package cfgport_pkg;

  typedef enum logic [1:0] {
    KS_RUN  = 2'd0,
    KS_HALF = 2'd1,
    KS_CFG  = 2'd2
  } key_st_e;

  localparam logic [7:0] KEY_OPEN  = 8'h55;
  localparam logic [7:0] KEY_CLOSE = 8'hAA;
  localparam logic [7:0] CHIP_ID   = 8'h02;

  localparam logic [7:0] IX_LDN  = 8'h07;
  localparam logic [7:0] IX_ID   = 8'h20;
  localparam logic [7:0] IX_REV  = 8'h21;
  localparam logic [7:0] IX_PWR  = 8'h22;
  localparam logic [7:0] IX_ACT  = 8'h30;
  localparam logic [7:0] IX_AHI  = 8'h60;
  localparam logic [7:0] IX_ALO  = 8'h61;
  localparam logic [7:0] IX_IRQ  = 8'h70;
  localparam logic [7:0] IX_IRQ2 = 8'h72;
  localparam logic [7:0] IX_DMA  = 8'h74;
  localparam logic [7:0] IX_MODE = 8'h90;
  localparam logic [7:0] IX_OPT  = 8'h91;

endpackage

// File: rtl/cfgport_keyfsm.sv
module cfgport_keyfsm
  import cfgport_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_base,
  input  logic       wr_data,
  input  logic [7:0] wdata,
  output logic       cfg_on,
  output logic       half_on
);

  key_st_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      KS_RUN: begin
        if (wr_base && wdata == KEY_OPEN) st_d = KS_HALF;
      end
      KS_HALF: begin
        if (wr_base && wdata == KEY_OPEN) st_d = KS_CFG;
        else if (wr_base || wr_data)      st_d = KS_RUN;
      end
      KS_CFG: begin
        if (wr_base && wdata == KEY_CLOSE) st_d = KS_RUN;
      end
      default: st_d = KS_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= KS_RUN;
    else        st_q <= st_d;
  end

  assign cfg_on  = (st_q == KS_CFG);
  assign half_on = (st_q == KS_HALF);

endmodule

// File: rtl/cfgport_bank.sv
module cfgport_bank
  import cfgport_pkg::*;
#(
  parameter int IRQ_W    = 4,
  parameter int DMA_W    = 3,
  parameter bit HAS_IRQ2 = 1'b0,
  parameter bit HAS_DMA  = 1'b0,
  parameter bit HAS_MODE = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [7:0]       idx,
  input  logic [7:0]       wdata,
  output logic [7:0]       rdata,
  output logic             act,
  output logic [15:0]      base,
  output logic [IRQ_W-1:0] irq,
  output logic [IRQ_W-1:0] irq2,
  output logic [DMA_W-1:0] dma
);

  logic             act_q;
  logic [7:0]       ahi_q, alo_q;
  logic [IRQ_W-1:0] irq_q;
  logic             en_act, en_ahi, en_alo, en_irq;
  logic [7:0]       rd_irq2, rd_dma, rd_mode, rd_opt;

  always_comb begin
    en_act = wr_en && (idx == IX_ACT);
    en_ahi = wr_en && (idx == IX_AHI);
    en_alo = wr_en && (idx == IX_ALO);
    en_irq = wr_en && (idx == IX_IRQ);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      ahi_q <= '0;
      alo_q <= '0;
      irq_q <= '0;
    end else begin
      if (en_act) act_q <= wdata[0];
      if (en_ahi) ahi_q <= wdata;
      if (en_alo) alo_q <= wdata;
      if (en_irq) irq_q <= wdata[IRQ_W-1:0];
    end
  end

  generate
    if (HAS_IRQ2) begin : g_irq2
      logic [IRQ_W-1:0] irq2_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                       irq2_q <= '0;
        else if (wr_en && idx == IX_IRQ2) irq2_q <= wdata[IRQ_W-1:0];
      end
      always_comb begin
        rd_irq2 = '0;
        rd_irq2[IRQ_W-1:0] = irq2_q;
      end
      assign irq2 = irq2_q;
    end else begin : g_no_irq2
      assign rd_irq2 = '0;
      assign irq2    = '0;
    end

    if (HAS_DMA) begin : g_dma
      logic [DMA_W-1:0] dma_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      dma_q <= '0;
        else if (wr_en && idx == IX_DMA) dma_q <= wdata[DMA_W-1:0];
      end
      always_comb begin
        rd_dma = '0;
        rd_dma[DMA_W-1:0] = dma_q;
      end
      assign dma = dma_q;
    end else begin : g_no_dma
      assign rd_dma = '0;
      assign dma    = '0;
    end

    if (HAS_MODE) begin : g_mode
      logic [7:0] mode_q, opt_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          mode_q <= '0;
          opt_q  <= '0;
        end else begin
          if (wr_en && idx == IX_MODE) mode_q <= wdata;
          if (wr_en && idx == IX_OPT)  opt_q  <= wdata;
        end
      end
      assign rd_mode = mode_q;
      assign rd_opt  = opt_q;
    end else begin : g_no_mode
      assign rd_mode = '0;
      assign rd_opt  = '0;
    end
  endgenerate

  always_comb begin
    rdata = '0;
    unique case (idx)
      IX_ACT:  rdata[0] = act_q;
      IX_AHI:  rdata = ahi_q;
      IX_ALO:  rdata = alo_q;
      IX_IRQ:  rdata[IRQ_W-1:0] = irq_q;
      IX_IRQ2: rdata = rd_irq2;
      IX_DMA:  rdata = rd_dma;
      IX_MODE: rdata = rd_mode;
      IX_OPT:  rdata = rd_opt;
      default: rdata = '0;
    endcase
  end

  assign act  = act_q;
  assign base = {ahi_q, alo_q};
  assign irq  = irq_q;

endmodule

// File: rtl/cfgport_top.sv
module cfgport_top
  import cfgport_pkg::*;
#(
  parameter int         NDEV     = 9,
  parameter int         IRQ_W    = 4,
  parameter int         DMA_W    = 3,
  parameter logic [7:0] REV      = 8'h01,
  parameter int         FDD_LDN  = 0,
  parameter int         PAR_LDN  = 3,
  parameter int         KBD_LDN  = 7,
  parameter int         PWR_BITS = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    bus_wr,
  input  logic                    bus_rd,
  input  logic                    bus_port,
  input  logic [7:0]              bus_wdata,
  output logic [7:0]              bus_rdata,
  output logic [NDEV-1:0]         dev_active,
  output logic [NDEV*16-1:0]      dev_base,
  output logic [NDEV*IRQ_W-1:0]   dev_irq,
  output logic [NDEV*DMA_W-1:0]   dev_dma,
  output logic [IRQ_W-1:0]        kbd_irq2
);

  localparam int         LDN_W    = $clog2(NDEV);
  localparam logic [7:0] LDN_MAX8 = 8'(NDEV - 1);

  // reset: asserted asynchronously, released after two clock edges
  logic [1:0] rst_sr;
  logic       rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sr <= 2'b00;
    else        rst_sr <= {rst_sr[0], 1'b1};
  end
  assign rst_q_n = rst_sr[1];

  logic wr_base, wr_data, cfg_on, half_on;
  assign wr_base = bus_wr && !bus_port;
  assign wr_data = bus_wr &&  bus_port;

  cfgport_keyfsm u_key (
    .clk     (clk),
    .rst_n   (rst_q_n),
    .wr_base (wr_base),
    .wr_data (wr_data),
    .wdata   (bus_wdata),
    .cfg_on  (cfg_on),
    .half_on (half_on)
  );

  // index and logical device number
  logic [7:0]       idx_q, idx_d;
  logic [LDN_W-1:0] ldn_q, ldn_d;
  logic             idx_en, ldn_en;

  always_comb begin
    idx_en = cfg_on && wr_base && (bus_wdata != KEY_CLOSE);
    idx_d  = bus_wdata;
    ldn_en = cfg_on && wr_data && (idx_q == IX_LDN) && (bus_wdata <= LDN_MAX8);
    ldn_d  = bus_wdata[LDN_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      idx_q <= '0;
      ldn_q <= '0;
    end else begin
      if (idx_en) idx_q <= idx_d;
      if (ldn_en) ldn_q <= ldn_d;
    end
  end

  // per-device banks
  logic [7:0]       bank_rd [NDEV];
  logic [IRQ_W-1:0] irq2_v  [NDEV];

  for (genvar i = 0; i < NDEV; i++) begin : g_bank
    logic bank_we;
    assign bank_we = wr_data && cfg_on && (ldn_q == LDN_W'(i));

    cfgport_bank #(
      .IRQ_W    (IRQ_W),
      .DMA_W    (DMA_W),
      .HAS_IRQ2 (i == KBD_LDN),
      .HAS_DMA  ((i == FDD_LDN) || (i == PAR_LDN)),
      .HAS_MODE (i == FDD_LDN)
    ) u_bank (
      .clk   (clk),
      .rst_n (rst_q_n),
      .wr_en (bank_we),
      .idx   (idx_q),
      .wdata (bus_wdata),
      .rdata (bank_rd[i]),
      .act   (dev_active[i]),
      .base  (dev_base[i*16 +: 16]),
      .irq   (dev_irq[i*IRQ_W +: IRQ_W]),
      .irq2  (irq2_v[i]),
      .dma   (dev_dma[i*DMA_W +: DMA_W])
    );
  end

  // only the keyboard bank drives a nonzero second interrupt
  always_comb begin
    kbd_irq2 = '0;
    for (int i = 0; i < NDEV; i++) kbd_irq2 = kbd_irq2 | irq2_v[i];
  end

  // read path
  logic [7:0] pwr_v, data_rd;

  always_comb begin
    pwr_v = '0;
    pwr_v[PWR_BITS-1:0] = dev_active[PWR_BITS-1:0];
  end

  always_comb begin
    data_rd = '0;
    unique case (idx_q)
      IX_LDN:  data_rd[LDN_W-1:0] = ldn_q;
      IX_ID:   data_rd = CHIP_ID;
      IX_REV:  data_rd = REV;
      IX_PWR:  data_rd = pwr_v;
      default: data_rd = bank_rd[ldn_q];
    endcase
  end

  always_comb begin
    if (!bus_rd)       bus_rdata = 8'h00;
    else if (!cfg_on)  bus_rdata = 8'hFF;
    else if (bus_port) bus_rdata = data_rd;
    else               bus_rdata = idx_q;
  end

endmodule

// File: rtl/cfgport_chk.sv
module cfgport_chk #(
  parameter int NDEV = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_on,
  input logic              half_on,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic              bus_port,
  input logic [7:0]        bus_wdata,
  input logic [7:0]        bus_rdata,
  input logic [7:0]        idx_q,
  input logic [NDEV-1:0]   dev_active,
  input logic [NDEV*16-1:0] dev_base
);

  logic base_key, base_close;
  assign base_key   = bus_wr && !bus_port && (bus_wdata == 8'h55);
  assign base_close = bus_wr && !bus_port && (bus_wdata == 8'hAA);

  a_r1_single_key_stays_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_on && !half_on && base_key) |=> !cfg_on);

  a_r1_second_key_opens: assert property (@(posedge clk) disable iff (!rst_n)
    (half_on && base_key) |=> cfg_on);

  a_r2_other_write_cancels: assert property (@(posedge clk) disable iff (!rst_n)
    (half_on && bus_wr && !base_key) |=> (!cfg_on && !half_on));

  a_r3_close_key_locks: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_on && base_close) |=> !cfg_on);

  a_r4_locked_reads_ff: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_on && bus_rd) |-> (bus_rdata == 8'hFF));

  a_r4_locked_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_on && bus_wr && bus_port) |=> ($stable(dev_active) && $stable(dev_base)));

  a_r5_id_value: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_on && bus_rd && bus_port && idx_q == 8'h20) |-> (bus_rdata == 8'h02));

  a_r11_power_map: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_on && bus_rd && bus_port && idx_q == 8'h22)
      |-> (bus_rdata[5:0] == dev_active[5:0] && bus_rdata[7:6] == 2'b00));

endmodule

bind cfgport_top cfgport_chk #(.NDEV(NDEV)) chk_i (
  .clk        (clk),
  .rst_n      (rst_q_n),
  .cfg_on     (cfg_on),
  .half_on    (half_on),
  .bus_wr     (bus_wr),
  .bus_rd     (bus_rd),
  .bus_port   (bus_port),
  .bus_wdata  (bus_wdata),
  .bus_rdata  (bus_rdata),
  .idx_q      (idx_q),
  .dev_active (dev_active),
  .dev_base   (dev_base)
);

// File: tb/cfgport_top_tb_top.sv
`timescale 1ns/1ps
module cfgport_top_tb_top;

  localparam int NDEV = 9;
  localparam int IRQ_W = 4;
  localparam int DMA_W = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_wr = 1'b0, bus_rd = 1'b0, bus_port = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic [NDEV-1:0] dev_active;
  logic [NDEV*16-1:0] dev_base;
  logic [NDEV*IRQ_W-1:0] dev_irq;
  logic [NDEV*DMA_W-1:0] dev_dma;
  logic [IRQ_W-1:0] kbd_irq2;

  int n_cmp = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  cfgport_top dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_port(bus_port), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .dev_active(dev_active), .dev_base(dev_base), .dev_irq(dev_irq),
    .dev_dma(dev_dma), .kbd_irq2(kbd_irq2)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic port, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_port = port; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic port, output logic [7:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_port = port;
    #1 d = bus_rdata;
    bus_rd = 1'b0;
  endtask

  task automatic reg_wr(input logic [7:0] ix, input logic [7:0] d);
    wr(1'b0, ix); wr(1'b1, d);
  endtask

  task automatic reg_rd(input logic [7:0] ix, output logic [7:0] d);
    wr(1'b0, ix); rd(1'b1, d);
  endtask

  task automatic unlock();
    wr(1'b0, 8'h55); wr(1'b0, 8'h55);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    check("R13 reset active", 32'(dev_active), 32'h0);
    check("R13 reset base dev4", 32'(dev_base[4*16 +: 16]), 32'h0);
    check("R13 reset irq", 32'(dev_irq), 32'h0);
    check("R13 reset dma", 32'(dev_dma), 32'h0);
    rd(1'b1, v);
    check("R4 locked read after reset", 32'(v), 32'hFF);
  endtask

  task automatic t_keys();
    logic [7:0] v;
    wr(1'b0, 8'h55);
    wr(1'b0, 8'h20);
    rd(1'b1, v);
    check("R1 one key stays locked", 32'(v), 32'hFF);
    wr(1'b0, 8'h55);
    wr(1'b1, 8'h55);
    wr(1'b0, 8'h55);
    rd(1'b1, v);
    check("R2 data write cancels key", 32'(v), 32'hFF);
    wr(1'b0, 8'hAA);
    wr(1'b0, 8'h55);
    wr(1'b0, 8'h13);
    wr(1'b0, 8'h55);
    rd(1'b1, v);
    check("R2 base write cancels key", 32'(v), 32'hFF);
    wr(1'b0, 8'hAA);
    unlock();
    reg_rd(8'h20, v);
    check("R1 two keys open", 32'(v), 32'h02);
  endtask

  task automatic t_ident();
    logic [7:0] v;
    reg_rd(8'h21, v);
    check("R5 revision", 32'(v), 32'h01);
    reg_wr(8'h20, 8'h77);
    rd(1'b1, v);
    check("R5 id read only", 32'(v), 32'h02);
    rd(1'b0, v);
    check("R3 base read gives index", 32'(v), 32'h20);
  endtask

  task automatic t_ldn();
    logic [7:0] v;
    reg_wr(8'h07, 8'h05);
    rd(1'b1, v);
    check("R6 ldn readback", 32'(v), 32'h05);
    reg_wr(8'h07, 8'h09);
    rd(1'b1, v);
    check("R6 ldn above 8 ignored", 32'(v), 32'h05);
  endtask

  task automatic t_banks();
    logic [7:0] v;
    reg_wr(8'h07, 8'h04);
    reg_wr(8'h60, 8'h03); reg_wr(8'h61, 8'hF8); reg_wr(8'h70, 8'h04); reg_wr(8'h30, 8'h01);
    reg_wr(8'h07, 8'h05);
    reg_wr(8'h60, 8'h02); reg_wr(8'h61, 8'hF8); reg_wr(8'h70, 8'h1C); reg_wr(8'h30, 8'h01);
    check("R7 base dev4", 32'(dev_base[4*16 +: 16]), 32'h03F8);
    check("R7 base dev5", 32'(dev_base[5*16 +: 16]), 32'h02F8);
    check("R7 irq dev4", 32'(dev_irq[4*IRQ_W +: IRQ_W]), 32'h4);
    check("R7 irq dev5 low bits", 32'(dev_irq[5*IRQ_W +: IRQ_W]), 32'hC);
    check("R7 active map", 32'(dev_active), 32'h030);
    reg_rd(8'h70, v);
    check("R7 irq readback", 32'(v), 32'h0C);
    reg_rd(8'h60, v);
    check("R7 addr hi readback", 32'(v), 32'h02);
  endtask

  task automatic t_timing();
    reg_wr(8'h07, 8'h03);
    wr(1'b0, 8'h30);
    @(negedge clk);
    bus_wr = 1'b1; bus_port = 1'b1; bus_wdata = 8'h01;
    #1 check("R13 before edge", 32'(dev_active[3]), 32'h0);
    @(negedge clk);
    bus_wr = 1'b0;
    check("R13 after edge", 32'(dev_active[3]), 32'h1);
  endtask

  task automatic t_kbd();
    logic [7:0] v;
    reg_wr(8'h07, 8'h07);
    reg_wr(8'h72, 8'h0C);
    check("R8 kbd irq2 out", 32'(kbd_irq2), 32'hC);
    reg_rd(8'h72, v);
    check("R8 kbd irq2 readback", 32'(v), 32'h0C);
    reg_wr(8'h07, 8'h04);
    reg_wr(8'h72, 8'h05);
    rd(1'b1, v);
    check("R8 irq2 absent dev4", 32'(v), 32'h00);
    check("R8 kbd irq2 kept", 32'(kbd_irq2), 32'hC);
  endtask

  task automatic t_dma();
    logic [7:0] v;
    reg_wr(8'h07, 8'h00); reg_wr(8'h74, 8'h02);
    reg_wr(8'h07, 8'h03); reg_wr(8'h74, 8'h03);
    check("R9 dma dev0", 32'(dev_dma[0 +: DMA_W]), 32'h2);
    check("R9 dma dev3", 32'(dev_dma[3*DMA_W +: DMA_W]), 32'h3);
    reg_wr(8'h07, 8'h05); reg_wr(8'h74, 8'h01);
    rd(1'b1, v);
    check("R9 dma absent read", 32'(v), 32'h00);
    check("R9 dma absent out", 32'(dev_dma[5*DMA_W +: DMA_W]), 32'h0);
  endtask

  task automatic t_mode();
    logic [7:0] v;
    reg_wr(8'h07, 8'h00);
    reg_wr(8'h90, 8'h41);
    rd(1'b1, v);
    check("R10 mode readback", 32'(v), 32'h41);
    wr(1'b1, v | 8'h0E);
    rd(1'b1, v);
    check("R10 mode rmw", 32'(v), 32'h4F);
    reg_wr(8'h91, 8'h5A);
    rd(1'b1, v);
    check("R10 option readback", 32'(v), 32'h5A);
    reg_wr(8'h07, 8'h02);
    reg_rd(8'h90, v);
    check("R10 mode absent dev2", 32'(v), 32'h00);
  endtask

  task automatic t_power();
    logic [7:0] v;
    reg_wr(8'h07, 8'h07);
    reg_wr(8'h30, 8'h01);
    reg_rd(8'h22, v);
    check("R11 power map", 32'(v), 32'h38);
  endtask

  task automatic t_unimpl();
    logic [7:0] v;
    reg_wr(8'h07, 8'h04);
    reg_wr(8'h40, 8'h99);
    rd(1'b1, v);
    check("R12 unused index read", 32'(v), 32'h00);
    reg_rd(8'h23, v);
    check("R12 unused global read", 32'(v), 32'h00);
    check("R12 base kept", 32'(dev_base[4*16 +: 16]), 32'h03F8);
    check("R12 active kept", 32'(dev_active), 32'h0B8);
  endtask

  task automatic t_lock();
    logic [7:0] v;
    reg_wr(8'h07, 8'h04);
    wr(1'b0, 8'h30);
    wr(1'b0, 8'hAA);
    rd(1'b1, v);
    check("R3 locked after close", 32'(v), 32'hFF);
    wr(1'b1, 8'h00);
    check("R4 locked write ignored", 32'(dev_active[4]), 32'h1);
    wr(1'b0, 8'h61);
    unlock();
    rd(1'b1, v);
    check("R4 active still set", 32'(v), 32'h01);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_keys();
    t_ident();
    t_ldn();
    t_banks();
    t_timing();
    t_kbd();
    t_dma();
    t_mode();
    t_power();
    t_unimpl();
    t_lock();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp + 1, n_bad + 1);
    $finish;
  end

endmodule